// File: doc/BRIEF.md
# Single-Line Bus Slave Bit Responder

This block is the bit layer of a slave on a single-wire open-drain bus. It watches an already synchronized copy of the line and times everything from the falling edges the master makes. A low period long enough to be a reset is reported to the layer above with a one-cycle strobe. Once the line rises again, the block answers with a delayed presence pulse.

Every other falling edge opens a time slot. With the transmit-mode input low, the slot is treated as a master write: the line is sampled once, part way into the slot, and the result is handed up as a received bit with a valid strobe. With transmit mode high, the slot is a master read. The block either leaves the line released to send a 1, or holds it low for a fixed time to send a 0.

All timing is set in microseconds and scaled by one parameter, the number of clock cycles per microsecond (C below). Transmit mode and the bit to send are captured at the falling edge that opens the slot.

Top module: `ow_bit_responder`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, drive_low, rx_valid and reset_seen are all 0.
- R2: If the line is sampled low on 480*C consecutive clock edges while the block is not driving it, reset_seen is high for exactly one cycle, on the edge of the 480*C-th low sample. A low lasting 480*C-1 samples gives no reset_seen.
- R3: Take the edge at which the line is first sampled high after a detected reset. drive_low goes high 30*C cycles after that edge and stays high for exactly 60*C cycles.
- R4: With tx_mode low at the opening falling edge, rx_valid is high for exactly one cycle, 30*C cycles after that edge. rx_bit then shows the line level sampled one cycle earlier: 1 if high, 0 if low. The low period of a reset also opens a slot, so it yields an rx_valid carrying 0, 30*C cycles after its falling edge.
- R5: With tx_mode high and tx_bit 0 at the opening falling edge, drive_low is high for exactly 30*C cycles, starting at that edge. No rx_valid is produced for the slot.
- R6: With tx_mode high and tx_bit 1 at the opening falling edge, drive_low stays low and no rx_valid is produced for the slot.
- R7: A new slot is accepted once 60*C cycles of the current slot have passed. Slots separated by a recovery of only 1 µs are each decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Synchronized bus line level, 1 = released/high |
| tx_mode | input | 1 | 1: treat the next slot as a master read, 0: as a master write |
| tx_bit | input | 1 | Bit to send in a read slot |
| drive_low | output | 1 | 1 pulls the open-drain line low |
| rx_bit | output | 1 | Last bit received in a write slot |
| rx_valid | output | 1 | One-cycle strobe, rx_bit is new |
| reset_seen | output | 1 | One-cycle strobe, a master reset was detected |

## Verification
The timing origins are counted from the first clock edge that samples the new line level, not from the cycle in which the bench changes the line. The valid strobe is due 30*C edges after that origin. The reset strobe is due on the edge of the 480*C-th low sample. A presence or read-0 drive occupies a half-open window of edges measured from the same origins. The bench turns every stimulus into these expected cycle numbers as it issues it. It then compares all four outputs against them on every falling clock edge, so a strobe that comes one cycle early or late is caught in the cycle where it goes wrong.

// File: rtl/ow_bit_responder.sv
module ow_bit_responder #(
  parameter int CLKS_PER_US = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic tx_mode,
  input  logic tx_bit,
  output logic drive_low,
  output logic rx_bit,
  output logic rx_valid,
  output logic reset_seen
);
  localparam int RST_C  = 480 * CLKS_PER_US;
  localparam int PDLY_C = 30 * CLKS_PER_US;
  localparam int PLEN_C = 60 * CLKS_PER_US;
  localparam int SAMP_C = 30 * CLKS_PER_US;
  localparam int HOLD_C = 30 * CLKS_PER_US;
  localparam int SLOT_C = 60 * CLKS_PER_US;
  localparam int CW = $clog2(PLEN_C + 1);
  localparam int LW = $clog2(RST_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_SLOT, S_RLOW, S_PWAIT, S_PDRV} st_t;

  st_t st;
  logic line_q, slot_tx;
  logic [CW-1:0] cnt;
  logic [LW-1:0] lowcnt;

  wire fall      = line_q & ~line_in & ~drive_low;
  wire slot_done = cnt >= CW'(SLOT_C - 1);
  wire start     = fall && (st == S_IDLE || (st == S_SLOT && slot_done));
  wire rst_hit   = ~line_in && ~drive_low && lowcnt == LW'(RST_C - 1) && st != S_RLOW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      line_q     <= 1'b1;
      slot_tx    <= 1'b0;
      cnt        <= '0;
      lowcnt     <= '0;
      drive_low  <= 1'b0;
      rx_bit     <= 1'b0;
      rx_valid   <= 1'b0;
      reset_seen <= 1'b0;
    end else begin
      line_q     <= line_in;
      rx_valid   <= 1'b0;
      reset_seen <= 1'b0;
      if (line_in || drive_low)      lowcnt <= '0;
      else if (lowcnt != LW'(RST_C)) lowcnt <= lowcnt + LW'(1);
      if (cnt != CW'(PLEN_C)) cnt <= cnt + CW'(1);

      if (rst_hit) begin
        st         <= S_RLOW;
        reset_seen <= 1'b1;
        drive_low  <= 1'b0;
      end else if (start) begin
        st        <= S_SLOT;
        cnt       <= '0;
        slot_tx   <= tx_mode;
        drive_low <= tx_mode & ~tx_bit;
      end else begin
        case (st)
          S_SLOT: begin
            if (!slot_tx && cnt == CW'(SAMP_C - 1)) begin
              rx_bit   <= line_in;
              rx_valid <= 1'b1;
            end
            if (slot_tx && cnt == CW'(HOLD_C - 1)) drive_low <= 1'b0;
            if (slot_done && line_in) st <= S_IDLE;
          end
          S_RLOW: if (line_in) begin
            st  <= S_PWAIT;
            cnt <= '0;
          end
          S_PWAIT: if (cnt == CW'(PDLY_C - 1)) begin
            st        <= S_PDRV;
            cnt       <= '0;
            drive_low <= 1'b1;
          end
          S_PDRV: if (cnt == CW'(PLEN_C - 1)) begin
            st        <= S_IDLE;
            drive_low <= 1'b0;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ow_bit_responder_chk.sv
module ow_bit_responder_chk #(
  parameter int CLKS_PER_US = 4
) (
  input logic clk,
  input logic rst_n,
  input logic line_in,
  input logic tx_mode,
  input logic tx_bit,
  input logic drive_low,
  input logic rx_bit,
  input logic rx_valid,
  input logic reset_seen
);
  localparam int HOLD_C = 30 * CLKS_PER_US;
  localparam int PLEN_C = 60 * CLKS_PER_US;
  localparam int RW = $clog2(PLEN_C + 2);

  logic [RW-1:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (drive_low) begin
      if (run != RW'(PLEN_C + 1)) run <= run + RW'(1);
    end else run <= '0;
  end

  a_r2_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |=> !reset_seen);
  a_r2_rst_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_seen) |-> $past(!line_in));
  a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r5_drive_pulls_line: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> !line_in);
  a_r3_drive_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> (run == RW'(HOLD_C) || run == RW'(PLEN_C)));
endmodule

bind ow_bit_responder ow_bit_responder_chk #(.CLKS_PER_US(CLKS_PER_US)) u_chk (.*);

// File: tb/ow_bit_responder_bench.sv
module ow_bit_responder_bench;
  localparam int CLK_NS = 10;
  localparam int C = 4;
  localparam int RST = 480 * C;
  localparam int PDLY = 30 * C;
  localparam int PLEN = 60 * C;
  localparam int SAMP = 30 * C;
  localparam int HOLD = 30 * C;

  logic clk = 0, rst_n = 0, m_low = 0, tx_mode = 0, tx_bit = 0;
  logic drive_low, rx_bit, rx_valid, reset_seen;
  wire line_in;
  assign line_in = ~(m_low | drive_low);

  ow_bit_responder #(.CLKS_PER_US(C)) u_ow_bit_responder (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .tx_mode(tx_mode), .tx_bit(tx_bit),
    .drive_low(drive_low), .rx_bit(rx_bit), .rx_valid(rx_valid), .reset_seen(reset_seen));

  always #(CLK_NS / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int drv_s[$], drv_e[$], val_c[$], rst_c[$];
  bit val_b[$];
  int tests = 0, fails = 0, obs_val = 0, obs_drv = 0, obs_rst = 0;
  string tag = "R1";
  bit done = 0;

  task automatic chk(string r, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int e_drv, e_val, e_bit, e_rst;
      e_drv = 0; e_val = 0; e_bit = 0; e_rst = 0;
      foreach (drv_s[i]) if (cyc >= drv_s[i] && cyc < drv_e[i]) e_drv = 1;
      foreach (val_c[i]) if (cyc == val_c[i]) begin e_val = 1; e_bit = val_b[i]; end
      foreach (rst_c[i]) if (cyc == rst_c[i]) e_rst = 1;
      chk({tag, " drive_low"}, drive_low, e_drv);
      chk({tag, " rx_valid"}, rx_valid, e_val);
      if (e_val) chk({tag, " rx_bit"}, rx_bit, e_bit);
      chk({tag, " reset_seen"}, reset_seen, e_rst);
      obs_val += rx_valid;
      obs_drv += drive_low;
      obs_rst += reset_seen;
    end
  end

  task automatic wr(bit b, bit tight);
    int e0;
    @(negedge clk);
    tx_mode = 0; m_low = 1; e0 = cyc + 1;
    val_c.push_back(e0 + SAMP); val_b.push_back(b);
    repeat (b ? 5 * C : 60 * C) @(negedge clk);
    m_low = 0;
    repeat (tight ? (b ? 55 * C : C - 1) : (b ? 65 * C : 10 * C)) @(negedge clk);
  endtask

  task automatic rd(bit b);
    int e0;
    @(negedge clk);
    tx_mode = 1; tx_bit = b; m_low = 1; e0 = cyc + 1;
    if (!b) begin drv_s.push_back(e0); drv_e.push_back(e0 + HOLD); end
    repeat (C) @(negedge clk);
    m_low = 0;
    repeat (70 * C) @(negedge clk);
    tx_mode = 0;
  endtask

  task automatic low_pulse(int len);
    int e0;
    @(negedge clk);
    tx_mode = 0; m_low = 1; e0 = cyc + 1;
    val_c.push_back(e0 + SAMP); val_b.push_back(1'b0);
    if (len >= RST) begin
      rst_c.push_back(e0 + RST - 1);
      drv_s.push_back(e0 + len + PDLY); drv_e.push_back(e0 + len + PDLY + PLEN);
    end
    repeat (len) @(negedge clk);
    m_low = 0;
    repeat (PDLY + PLEN + 20 * C) @(negedge clk);
  endtask

  initial begin
    int v0, d0, r0;
    repeat (3) @(negedge clk);
    chk("R1 reset drive_low", drive_low, 0);
    chk("R1 reset rx_valid", rx_valid, 0);
    chk("R1 reset reset_seen", reset_seen, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release drive_low", drive_low, 0);
    repeat (10) @(negedge clk);

    tag = "R4"; v0 = obs_val; d0 = obs_drv;
    wr(1, 0); wr(0, 0); wr(1, 0); wr(1, 0); wr(0, 0);
    #1;
    chk("R4 write slot count", obs_val - v0, 5);
    chk("R4 no drive in writes", obs_drv - d0, 0);

    tag = "R5"; v0 = obs_val; d0 = obs_drv;
    rd(0);
    #1;
    chk("R5 read-0 drive cycles", obs_drv - d0, HOLD);
    chk("R5 read-0 no rx_valid", obs_val - v0, 0);

    tag = "R6"; v0 = obs_val; d0 = obs_drv;
    rd(1);
    #1;
    chk("R6 read-1 drive cycles", obs_drv - d0, 0);
    chk("R6 read-1 no rx_valid", obs_val - v0, 0);

    tag = "R2"; r0 = obs_rst; d0 = obs_drv; v0 = obs_val;
    low_pulse(RST - 1);
    #1;
    chk("R2 short low gives no reset", obs_rst - r0, 0);
    chk("R2 short low gives no presence", obs_drv - d0, 0);
    chk("R2 short low decoded as write 0", obs_val - v0, 1);

    tag = "R3"; r0 = obs_rst; d0 = obs_drv;
    low_pulse(RST);
    #1;
    chk("R2 reset strobe count", obs_rst - r0, 1);
    chk("R3 presence drive cycles", obs_drv - d0, PLEN);
    low_pulse(RST + 50 * C);
    #1;
    chk("R3 second presence after long low", obs_drv - d0, 2 * PLEN);

    tag = "R7"; v0 = obs_val;
    wr(0, 1); wr(1, 1); wr(0, 1); wr(0, 1); wr(1, 0);
    #1;
    chk("R7 tight slots all decoded", obs_val - v0, 5);

    tag = "R5"; d0 = obs_drv;
    rd(0); rd(1); rd(0);
    #1;
    chk("R5 mixed read drive cycles", obs_drv - d0, 2 * HOLD);

    repeat (20) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule